// File: doc/BRIEF.md
# Low-Power Mode Control Register

This block is the byte-wide control register behind a microcontroller's power management, together with the small sequencer that turns register writes into low-power mode entries. Software writes one byte over the CPU bus. A single write can request sleep, stop, time-base-timer or timer mode, set the pin behaviour for the deep modes, choose a CPU clock-suspend count for intermittent operation, and fire a short internal reset pulse.

The mode a write selects depends on live status. A stop request becomes a stop entry when the oscillator clock drives the core, and a time-base-timer entry when the PLL clock does. A timer-mode request becomes a timer entry on the sub-clock and a time-base-timer entry otherwise. Some bits act on a written 1 and others on a written 0, and each action bit reads back a fixed value. The block holds the current mode in a one-hot register until the matching cancel event returns it to run. Clock gating, oscillator control and wake-up detection belong to the surrounding logic.

Top module: `lpm_ctrl_reg`

## Requirements
- R1: After reset the mode is run (`mode_o` = 5'b00001), all request strobes, `int_rst` and `pins_hiz` are low, `suspend_sel` is 00 and `rd_data` is 8'h19.
- R2: `rd_data` bits 7 and 6 always read 0. Bits 4, 3 and 0 always read 1. Bit 5 and bits 2:1 read the last accepted written values.
- R3: A write accepted in run mode with bit 7 = 1 enters stop mode and pulses `req_stop` when `clk_osc_sel` = 1 in the write cycle. It enters time-base-timer mode and pulses `req_tbt` when `clk_osc_sel` = 0.
- R4: A write in run mode with bit 7 = 0 and bit 6 = 1 enters sleep mode and pulses `req_sleep`. When bits 7 and 6 are both 1, R3 applies.
- R5: A write in run mode with bits 7 and 6 at 0 and bit 3 = 0 enters timer mode (`req_timer`) when `sub_clk_mode` = 1, and time-base-timer mode (`req_tbt`) otherwise.
- R6: Mode encodings are one-hot: run 00001, sleep 00010, time-base-timer 00100, stop 01000, timer 10000. `req_o` strobes last one cycle and at most one is high at a time. Mode requests written outside run mode are ignored, while bits 5 and 2:1 are still stored.
- R7: Sleep exits to run on `cancel_sleep` or `cancel_stop`. Time-base-timer exits on `cancel_tbt` or `cancel_stop`. Stop exits only on `cancel_stop`. Timer exits on `cancel_timer` or `irq`. Any other cancel leaves the mode unchanged.
- R8: `pins_hiz` is high exactly when stored bit 5 is 1 and the mode is time-base-timer, stop or timer.
- R9: A write with bit 4 = 0 raises `int_rst` on the clock edge that takes the write. `int_rst` falls on the third later edge at which `mc_en` is high.
- R10: While `int_rst` is high, writes are ignored entirely.
- R11: `suspend_sel` equals written bits 2:1 after each accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_en | input | 1 | Machine-cycle enable for the reset pulse timer |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data |
| clk_osc_sel | input | 1 | 1 = oscillator clock selected, 0 = PLL clock |
| sub_clk_mode | input | 1 | 1 = core runs from the sub-clock |
| irq | input | 1 | Interrupt request; leaves timer mode |
| cancel_sleep | input | 1 | Sleep cancel event |
| cancel_tbt | input | 1 | Time-base-timer cancel event |
| cancel_stop | input | 1 | Stop cancel event |
| cancel_timer | input | 1 | Timer-mode cancel event |
| req_sleep | output | 1 | Sleep entry strobe |
| req_stop | output | 1 | Stop entry strobe |
| req_tbt | output | 1 | Time-base-timer entry strobe |
| req_timer | output | 1 | Timer entry strobe |
| mode_o | output | 5 | One-hot current mode |
| pins_hiz | output | 1 | External pins to high impedance |
| int_rst | output | 1 | Internal reset pulse |
| suspend_sel | output | 2 | CPU clock-suspend count select |

## Verification
The assertions assume that `clk_osc_sel` and `wr_data` are steady across the write edge, because the stop strobe is traced back to the select level at that edge. They also assume that cancel events only arrive as single-cycle pulses. The stimulus changes every input one time unit after a rising edge and holds it for whole cycles. Each cancel is raised for exactly one cycle, and `mc_en` is held low across part of a reset pulse so that the pulse length shows that it counts enabled cycles rather than clock edges.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int DATA_W = 8;

  // write-data field positions
  localparam int B_STOP  = 7;
  localparam int B_SLEEP = 6;
  localparam int B_HIZ   = 5;
  localparam int B_RST   = 4;
  localparam int B_TMR   = 3;
  localparam int B_CG_HI = 2;
  localparam int B_CG_LO = 1;
  localparam int B_RSV   = 0;

  // request strobe indices
  localparam int RQ_SLEEP = 0;
  localparam int RQ_STOP  = 1;
  localparam int RQ_TBT   = 2;
  localparam int RQ_TIMER = 3;
  localparam int RQ_N     = 4;

  typedef enum logic [4:0] {
    MODE_RUN   = 5'b00001,
    MODE_SLEEP = 5'b00010,
    MODE_TBT   = 5'b00100,
    MODE_STOP  = 5'b01000,
    MODE_TIMER = 5'b10000
  } lpm_mode_e;
endpackage

// File: rtl/lpm_write_decode.sv
module lpm_write_decode
  import lpm_pkg::*;
(
  input  logic      stop_bit,
  input  logic      sleep_bit,
  input  logic      tmr_bit_n,
  input  logic      clk_osc_sel,
  input  logic      sub_clk_mode,
  output lpm_mode_e target
);
  // stop request outranks sleep, sleep outranks the timer request
  always_comb begin
    target = MODE_RUN;
    if (stop_bit) begin
      target = clk_osc_sel ? MODE_STOP : MODE_TBT;
    end else if (sleep_bit) begin
      target = MODE_SLEEP;
    end else if (!tmr_bit_n) begin
      target = sub_clk_mode ? MODE_TIMER : MODE_TBT;
    end
  end
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  lpm_mode_e         target,
  input  logic              cancel_sleep,
  input  logic              cancel_tbt,
  input  logic              cancel_stop,
  input  logic              cancel_timer,
  input  logic              irq,
  output lpm_mode_e         mode_q,
  output logic [RQ_N-1:0]   req_q
);
  lpm_mode_e       mode_d;
  logic [RQ_N-1:0] req_d;

  always_comb begin
    mode_d = mode_q;
    req_d  = '0;
    unique case (mode_q)
      MODE_RUN: begin
        if (take && target != MODE_RUN) begin
          mode_d = target;
          unique case (target)
            MODE_SLEEP: req_d[RQ_SLEEP] = 1'b1;
            MODE_STOP:  req_d[RQ_STOP]  = 1'b1;
            MODE_TBT:   req_d[RQ_TBT]   = 1'b1;
            MODE_TIMER: req_d[RQ_TIMER] = 1'b1;
            default:    req_d           = '0;
          endcase
        end
      end
      MODE_SLEEP: if (cancel_sleep || cancel_stop) mode_d = MODE_RUN;
      MODE_TBT:   if (cancel_tbt   || cancel_stop) mode_d = MODE_RUN;
      MODE_STOP:  if (cancel_stop)                 mode_d = MODE_RUN;
      MODE_TIMER: if (cancel_timer || irq)         mode_d = MODE_RUN;
      default:    mode_d = MODE_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RUN;
      req_q  <= '0;
    end else begin
      mode_q <= mode_d;
      req_q  <= req_d;
    end
  end
endmodule

// File: rtl/lpm_rst_timer.sv
module lpm_rst_timer #(
  parameter int CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mc_en,
  input  logic start,
  output logic active
);
  localparam int             CNT_W = $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start) begin
      cnt_d = LOAD;
    end else if (mc_en && cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/lpm_ctrl_reg.sv
module lpm_ctrl_reg
  import lpm_pkg::*;
#(
  parameter int RST_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mc_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              clk_osc_sel,
  input  logic              sub_clk_mode,
  input  logic              irq,
  input  logic              cancel_sleep,
  input  logic              cancel_tbt,
  input  logic              cancel_stop,
  input  logic              cancel_timer,
  output logic              req_sleep,
  output logic              req_stop,
  output logic              req_tbt,
  output logic              req_timer,
  output logic [4:0]        mode_o,
  output logic              pins_hiz,
  output logic              int_rst,
  output logic [1:0]        suspend_sel
);
  logic            rst_busy;
  logic            wr_take;
  lpm_mode_e       target;
  lpm_mode_e       mode_q;
  logic [RQ_N-1:0] req_q;
  logic            hiz_q, hiz_d;
  logic [1:0]      cg_q, cg_d;
  logic            unused_rsv;

  assign unused_rsv = wr_data[B_RSV];
  assign wr_take    = wr_en && !rst_busy;

  lpm_write_decode u_dec (
    .stop_bit     (wr_data[B_STOP]),
    .sleep_bit    (wr_data[B_SLEEP]),
    .tmr_bit_n    (wr_data[B_TMR]),
    .clk_osc_sel  (clk_osc_sel),
    .sub_clk_mode (sub_clk_mode),
    .target       (target)
  );

  lpm_mode_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .take         (wr_take),
    .target       (target),
    .cancel_sleep (cancel_sleep),
    .cancel_tbt   (cancel_tbt),
    .cancel_stop  (cancel_stop),
    .cancel_timer (cancel_timer),
    .irq          (irq),
    .mode_q       (mode_q),
    .req_q        (req_q)
  );

  lpm_rst_timer #(.CYCLES(RST_CYCLES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .mc_en  (mc_en),
    .start  (wr_take && !wr_data[B_RST]),
    .active (rst_busy)
  );

  // stored configuration fields
  always_comb begin
    hiz_d = hiz_q;
    cg_d  = cg_q;
    if (wr_take) begin
      hiz_d = wr_data[B_HIZ];
      cg_d  = wr_data[B_CG_HI:B_CG_LO];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hiz_q <= 1'b0;
      cg_q  <= 2'b00;
    end else begin
      hiz_q <= hiz_d;
      cg_q  <= cg_d;
    end
  end

  always_comb begin
    rd_data          = '0;
    rd_data[B_HIZ]   = hiz_q;
    rd_data[B_RST]   = 1'b1;
    rd_data[B_TMR]   = 1'b1;
    rd_data[B_CG_HI:B_CG_LO] = cg_q;
    rd_data[B_RSV]   = 1'b1;
  end

  assign mode_o      = mode_q;
  assign req_sleep   = req_q[RQ_SLEEP];
  assign req_stop    = req_q[RQ_STOP];
  assign req_tbt     = req_q[RQ_TBT];
  assign req_timer   = req_q[RQ_TIMER];
  assign int_rst     = rst_busy;
  assign suspend_sel = cg_q;
  assign pins_hiz    = hiz_q &&
                       (mode_q == MODE_TBT || mode_q == MODE_STOP || mode_q == MODE_TIMER);
endmodule

// File: rtl/lpm_ctrl_reg_chk.sv
module lpm_ctrl_reg_chk
  import lpm_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [7:0]  wr_data,
  input logic [7:0]  rd_data,
  input logic        clk_osc_sel,
  input logic        cancel_stop,
  input logic        req_sleep,
  input logic        req_stop,
  input logic        req_tbt,
  input logic        req_timer,
  input logic [4:0]  mode_o,
  input logic        pins_hiz,
  input logic        int_rst,
  input logic [1:0]  suspend_sel
);
  logic [3:0] reqs;
  assign reqs = {req_timer, req_tbt, req_stop, req_sleep};

  AST_RD_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7:6] == 2'b00 && rd_data[4:3] == 2'b11 && rd_data[0]); // R2
  AST_STOP_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    req_stop |-> $past(clk_osc_sel) && $past(wr_en)); // R3
  AST_SLEEP_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    req_sleep |-> $past(wr_data[6] && !wr_data[7])); // R4
  AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(mode_o)); // R6
  AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reqs)); // R6
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (|reqs) |=> !(|reqs)); // R6
  AST_STOP_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == MODE_STOP && cancel_stop) |=> mode_o == MODE_RUN); // R7
  AST_HIZ_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    pins_hiz |-> rd_data[5] && (mode_o == MODE_TBT || mode_o == MODE_STOP ||
                                mode_o == MODE_TIMER)); // R8
  AST_RST_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_rst) |-> $past(wr_en && !wr_data[4])); // R9
  AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int_rst) |=> $stable(rd_data)); // R10
  AST_CG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !int_rst) |=> suspend_sel == $past(wr_data[2:1])); // R11
endmodule

bind lpm_ctrl_reg lpm_ctrl_reg_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .wr_data     (wr_data),
  .rd_data     (rd_data),
  .clk_osc_sel (clk_osc_sel),
  .cancel_stop (cancel_stop),
  .req_sleep   (req_sleep),
  .req_stop    (req_stop),
  .req_tbt     (req_tbt),
  .req_timer   (req_timer),
  .mode_o      (mode_o),
  .pins_hiz    (pins_hiz),
  .int_rst     (int_rst),
  .suspend_sel (suspend_sel)
);

// File: tb/lpm_ctrl_reg_test.sv
`timescale 1ns/100ps
module lpm_ctrl_reg_test;
  localparam logic [4:0] M_RUN = 5'b00001, M_SLP = 5'b00010, M_TBT = 5'b00100,
                         M_STP = 5'b01000, M_TMR = 5'b10000;
  // strobe vector order: {timer, tbt, stop, sleep}
  localparam logic [3:0] Q_NONE = 4'b0000, Q_SLP = 4'b0001, Q_STP = 4'b0010,
                         Q_TBT = 4'b0100, Q_TMR = 4'b1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mc_en = 1'b1, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic clk_osc_sel = 1'b0, sub_clk_mode = 1'b0, irq = 1'b0;
  logic cancel_sleep = 1'b0, cancel_tbt = 1'b0, cancel_stop = 1'b0, cancel_timer = 1'b0;
  logic [7:0] rd_data;
  logic req_sleep, req_stop, req_tbt, req_timer, pins_hiz, int_rst;
  logic [4:0] mode_o;
  logic [1:0] suspend_sel;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  typedef struct {
    int         rid;
    logic [4:0] mode;
    logic [3:0] req;
    logic       rst;
    logic       hiz;
    logic [7:0] rd;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  lpm_ctrl_reg uut (
    .clk(clk), .rst_n(rst_n), .mc_en(mc_en), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .clk_osc_sel(clk_osc_sel), .sub_clk_mode(sub_clk_mode),
    .irq(irq), .cancel_sleep(cancel_sleep), .cancel_tbt(cancel_tbt),
    .cancel_stop(cancel_stop), .cancel_timer(cancel_timer),
    .req_sleep(req_sleep), .req_stop(req_stop), .req_tbt(req_tbt),
    .req_timer(req_timer), .mode_o(mode_o), .pins_hiz(pins_hiz),
    .int_rst(int_rst), .suspend_sel(suspend_sel)
  );

  // monitor: compare every queued expectation at the falling edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t e;
      logic [3:0] got_req;
      e = sb.pop_front();
      got_req = {req_timer, req_tbt, req_stop, req_sleep};
      checks++;
      if (mode_o !== e.mode || got_req !== e.req || int_rst !== e.rst ||
          pins_hiz !== e.hiz || rd_data !== e.rd || suspend_sel !== e.rd[2:1]) begin
        failures++;
        $display("FAIL R%0d: mode=%b req=%b rst=%b hiz=%b rd=%h sus=%b expected mode=%b req=%b rst=%b hiz=%b rd=%h sus=%b",
                 e.rid, mode_o, got_req, int_rst, pins_hiz, rd_data, suspend_sel,
                 e.mode, e.req, e.rst, e.hiz, e.rd, e.rd[2:1]);
      end
    end
  end

  task automatic expect_st(int rid, logic [4:0] m, logic [3:0] q, logic r, logic h,
                           logic [7:0] rd);
    exp_t e;
    e.rid = rid; e.mode = m; e.req = q; e.rst = r; e.hiz = h; e.rd = rd;
    sb.push_back(e);
    @(negedge clk);
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic write(logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    expect_st(1, M_RUN, Q_NONE, 0, 0, 8'h19);            // R1 reset state

    write(8'h3F);
    expect_st(2, M_RUN, Q_NONE, 0, 0, 8'h3F);            // R2 fixed/stored read bits

    clk_osc_sel = 1'b0;
    write(8'hBF);
    expect_st(3, M_TBT, Q_TBT, 0, 1, 8'h3F);             // R3 PLL -> time-base timer
    step();
    expect_st(6, M_TBT, Q_NONE, 0, 1, 8'h3F);            // R6 strobe one cycle, mode held
    cancel_tbt = 1'b1; step(); cancel_tbt = 1'b0;
    expect_st(7, M_RUN, Q_NONE, 0, 0, 8'h3F);            // R7 tbt cancel

    clk_osc_sel = 1'b1;
    write(8'hBF);
    expect_st(3, M_STP, Q_STP, 0, 1, 8'h3F);             // R3 oscillator -> stop, R8 hi-Z
    cancel_tbt = 1'b1; step(); cancel_tbt = 1'b0;
    expect_st(7, M_STP, Q_NONE, 0, 1, 8'h3F);            // R7 wrong cancel ignored
    cancel_stop = 1'b1; step(); cancel_stop = 1'b0;
    expect_st(7, M_RUN, Q_NONE, 0, 0, 8'h3F);            // R7 stop cancel

    write(8'hDF);
    expect_st(4, M_STP, Q_STP, 0, 0, 8'h1F);             // R4 both bits -> stop wins, R8 held pins
    cancel_stop = 1'b1; step(); cancel_stop = 1'b0;
    expect_st(7, M_RUN, Q_NONE, 0, 0, 8'h1F);

    write(8'h5F);
    expect_st(4, M_SLP, Q_SLP, 0, 0, 8'h1F);             // R4 sleep entry
    write(8'h99);
    expect_st(6, M_SLP, Q_NONE, 0, 0, 8'h19);            // R6 request outside run ignored, R11 stored
    cancel_tbt = 1'b1; step(); cancel_tbt = 1'b0;
    expect_st(7, M_SLP, Q_NONE, 0, 0, 8'h19);            // R7 tbt cancel no effect in sleep
    cancel_sleep = 1'b1; step(); cancel_sleep = 1'b0;
    expect_st(7, M_RUN, Q_NONE, 0, 0, 8'h19);            // R7 sleep cancel

    clk_osc_sel = 1'b0; sub_clk_mode = 1'b1;
    write(8'h37);
    expect_st(5, M_TMR, Q_TMR, 0, 1, 8'h3F);             // R5 sub-clock -> timer
    irq = 1'b1; step(); irq = 1'b0;
    expect_st(7, M_RUN, Q_NONE, 0, 0, 8'h3F);            // R7 irq leaves timer
    write(8'h35);
    expect_st(11, M_TMR, Q_TMR, 0, 1, 8'h3D);            // R11 suspend select 10
    cancel_timer = 1'b1; step(); cancel_timer = 1'b0;
    expect_st(7, M_RUN, Q_NONE, 0, 0, 8'h3D);

    sub_clk_mode = 1'b0;
    write(8'h37);
    expect_st(5, M_TBT, Q_TBT, 0, 1, 8'h3F);             // R5 main clock -> time-base timer
    cancel_stop = 1'b1; step(); cancel_stop = 1'b0;
    expect_st(7, M_RUN, Q_NONE, 0, 0, 8'h3F);

    mc_en = 1'b0;
    write(8'h29);
    expect_st(9, M_RUN, Q_NONE, 1, 0, 8'h39);            // R9 pulse starts
    repeat (4) step();
    expect_st(9, M_RUN, Q_NONE, 1, 0, 8'h39);            // R9 held without mc_en
    write(8'hBF);
    expect_st(10, M_RUN, Q_NONE, 1, 0, 8'h39);           // R10 write during pulse ignored
    mc_en = 1'b1;
    step();
    expect_st(9, M_RUN, Q_NONE, 1, 0, 8'h39);
    step();
    expect_st(9, M_RUN, Q_NONE, 1, 0, 8'h39);
    step();
    expect_st(9, M_RUN, Q_NONE, 0, 0, 8'h39);            // R9 ends after third enabled edge
    write(8'hBF);
    expect_st(10, M_TBT, Q_TBT, 0, 1, 8'h3F);            // R10 writes accepted again
    cancel_tbt = 1'b1; step(); cancel_tbt = 1'b0;
    expect_st(7, M_RUN, Q_NONE, 0, 0, 8'h3F);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule